// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

This block is a small register, four bits wide by default, that does one of four things at each rising clock edge. A two-bit mode input picks the action. The register can keep its contents, move every bit one place toward the least significant end, move every bit one place toward the most significant end, or take a whole word from its parallel input. Each shift direction has its own fill bit, which supplies the bit that enters at the vacated end.

Both end bits are driven out as serial outputs, so several of these registers can be chained into a longer shifter, or one register can pass its contents bit by bit to another. An active-low clear empties the register at once, without waiting for a clock edge. The clear is released in step with the clock, so the register starts working again only on the third rising edge after the clear goes high.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros at once, whatever the mode and data inputs are.
- R2: After `clr_n` rises, `q` stays zero through the first two rising edges. The mode selected at the third rising edge is the first one to take effect.
- R3: Mode 2'b00 (hold) leaves `q` unchanged across the edge.
- R4: Mode 2'b01 moves bits toward the LSB. Bit k takes bit k+1 for k below W-1, and bit W-1 takes `fill_hi`.
- R5: Mode 2'b10 moves bits toward the MSB. Bit k takes bit k-1 for k above 0, and bit 0 takes `fill_lo`.
- R6: Mode 2'b11 copies `par_in` into `q` bit for bit.
- R7: `out_lo` always equals `q[0]` and `out_hi` always equals `q[W-1]`.
- R8: The inputs a mode does not use have no effect on the result. These are `fill_lo` in mode 01, `fill_hi` in mode 10, both fill bits in modes 00 and 11, and `par_in` in every mode except 11.
- R9: Repeated shifts toward the LSB produce 1000, 0100, 0010, 0001 from 1000 when `fill_hi` is 0. They produce 1000, 1100, 1110, 1111 from 0000 when `fill_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asserts at once, releases in step with the clock |
| mode | input | 2 | 00 hold, 01 shift toward LSB, 10 shift toward MSB, 11 load |
| fill_hi | input | 1 | Bit that enters the MSB during a shift toward the LSB |
| fill_lo | input | 1 | Bit that enters the LSB during a shift toward the MSB |
| par_in | input | W | Word taken in by a load |
| q | output | W | Register contents |
| out_lo | output | 1 | Bit leaving the LSB end (q[0]) |
| out_hi | output | 1 | Bit leaving the MSB end (q[W-1]) |

## Verification
The bench loads each of the sixteen start values and then applies every mode with every fill-bit pair and every `par_in` word. A design that swapped the fill bits, or that mixed up the two shift directions, would give wrong end bits. A design that let `par_in` leak into a shift or a hold would change bits that should not move. The clear is dropped between edges and checked before the next edge, which catches a clear that waits for the clock. The edges after the clear is released are counted, which catches a release that is one edge early or one edge late. The chained-transfer scenario moves one register's word into a second register through the serial ends, which exposes an output tapped from the wrong end.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Action encoding on the mode input.
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_TO_LSB = 2'b01,
    MODE_TO_MSB = 2'b10,
    MODE_LOAD   = 2'b11
  } bsr_mode_e;

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  // Asserts asynchronously, releases after STAGES rising edges.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/bsr_bit_sel.sv
module bsr_bit_sel
  import bsr_pkg::*;
(
  input  bsr_mode_e sel,
  input  logic      keep_v,
  input  logic      from_hi,
  input  logic      from_lo,
  input  logic      load_v,
  output logic      next_v
);

  // Four-way selector for one register bit.
  always_comb begin
    unique case (sel)
      MODE_HOLD:   next_v = keep_v;
      MODE_TO_LSB: next_v = from_hi;
      MODE_TO_MSB: next_v = from_lo;
      MODE_LOAD:   next_v = load_v;
      default:     next_v = keep_v;
    endcase
  end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int W          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         fill_hi,
  input  logic         fill_lo,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         out_lo,
  output logic         out_hi
);

  localparam int MSB = W - 1;

  bsr_mode_e    mode_e;
  logic         rst_sync_n;
  logic         upd_en;
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  assign mode_e = bsr_mode_e'(mode);

  bsr_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .clr_n   (clr_n),
    .rst_q_n (rst_sync_n)
  );

  // Next-state: one selector per bit, neighbours wired by position.
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic hi_src;
    logic lo_src;

    if (k == MSB) begin : g_top
      assign hi_src = fill_hi;
    end else begin : g_mid_hi
      assign hi_src = q_r[k+1];
    end

    if (k == 0) begin : g_bot
      assign lo_src = fill_lo;
    end else begin : g_mid_lo
      assign lo_src = q_r[k-1];
    end

    bsr_bit_sel sel_i (
      .sel     (mode_e),
      .keep_v  (q_r[k]),
      .from_hi (hi_src),
      .from_lo (lo_src),
      .load_v  (par_in[k]),
      .next_v  (q_d[k])
    );
  end

  // Clock enable: hold does not toggle the flops.
  always_comb begin
    upd_en = (mode_e != MODE_HOLD);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_d;
    end
  end

  assign q      = q_r;
  assign out_lo = q_r[0];
  assign out_hi = q_r[MSB];

endmodule

// File: rtl/bidir_shift_reg_chk.sv
module bidir_shift_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic         rst_q_n,
  input logic [1:0]   mode,
  input logic         fill_hi,
  input logic         fill_lo,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q
);

  logic live;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) live <= 1'b0;
    else        live <= rst_q_n;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clr_n |-> (q == '0)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
    (live && mode == 2'b00) |=> $stable(q)); // R3

  AST_SHIFT_TO_LSB: assert property (@(posedge clk) disable iff (!clr_n)
    (live && mode == 2'b01) |=> (q == {$past(fill_hi), $past(q[W-1:1])})); // R4

  AST_SHIFT_TO_MSB: assert property (@(posedge clk) disable iff (!clr_n)
    (live && mode == 2'b10) |=> (q == {$past(q[W-2:0]), $past(fill_lo)})); // R5

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!clr_n)
    (live && mode == 2'b11) |=> (q == $past(par_in))); // R6

endmodule

bind bidir_shift_reg bidir_shift_reg_chk #(.W(W)) chk_i (
  .clk     (clk),
  .clr_n   (clr_n),
  .rst_q_n (rst_sync_n),
  .mode    (mode),
  .fill_hi (fill_hi),
  .fill_lo (fill_lo),
  .par_in  (par_in),
  .q       (q)
);

// File: tb/bidir_shift_reg_tb_top.sv
module bidir_shift_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk;
  logic         clr_n;
  logic [1:0]   mode;
  logic         fill_hi, fill_lo;
  logic [W-1:0] par_in;
  logic [W-1:0] q;
  logic         out_lo, out_hi;

  logic [1:0]   mode_b;
  logic         fill_hi_b, fill_lo_b;
  logic [W-1:0] par_in_b;
  logic [W-1:0] q_b;
  logic         out_lo_b, out_hi_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bidir_shift_reg #(.W(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .mode(mode), .fill_hi(fill_hi),
    .fill_lo(fill_lo), .par_in(par_in), .q(q), .out_lo(out_lo), .out_hi(out_hi)
  );

  // Second register for the chained transfer scenario.
  bidir_shift_reg #(.W(W)) dut_b (
    .clk(clk), .clr_n(clr_n), .mode(mode_b), .fill_hi(fill_hi_b),
    .fill_lo(fill_lo_b), .par_in(par_in_b), .q(q_b), .out_lo(out_lo_b), .out_hi(out_hi_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic fh, input logic fl, input logic [W-1:0] p);
    @(negedge clk);
    mode = m; fill_hi = fh; fill_lo = fl; par_in = p;
    @(posedge clk);
    #1;
  endtask

  function automatic int model(input int s, input int m, input int fh, input int fl, input int p);
    case (m)
      0: return s;
      1: return (s >> 1) | (fh << (W-1));
      2: return ((s << 1) & ((1 << W) - 1)) | fl;
      default: return p;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b1; mode = 2'b00; fill_hi = 0; fill_lo = 0; par_in = '0;
    mode_b = 2'b00; fill_hi_b = 0; fill_lo_b = 0; par_in_b = '0;
    #1 clr_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset q", int'(q), 0);

    // R2: release counting with a pending load of 1010
    mode = 2'b11; par_in = 4'b1010;
    @(negedge clk); clr_n = 1'b1;
    @(posedge clk); #1; check("R2 edge1", int'(q), 0);
    @(posedge clk); #1; check("R2 edge2", int'(q), 0);
    @(posedge clk); #1; check("R2 edge3", int'(q), 4'b1010);

    // Exhaustive sweep R3..R8
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 4; f++) begin
          for (int p = 0; p < 16; p++) begin
            int exp;
            step(2'b11, 0, 0, 4'(s));
            step(2'(m), f[1], f[0], 4'(p));
            exp = model(s, m, f[1], f[0], p);
            case (m)
              0: check("R3/R8 hold", int'(q), exp);
              1: check("R4/R8 to-lsb", int'(q), exp);
              2: check("R5/R8 to-msb", int'(q), exp);
              default: check("R6/R8 load", int'(q), exp);
            endcase
            check("R7 out_lo", int'(out_lo), exp & 1);
            check("R7 out_hi", int'(out_hi), (exp >> (W-1)) & 1);
          end
        end
      end
    end

    // R9 sequences
    step(2'b11, 0, 0, 4'b1000);
    step(2'b01, 0, 1, 4'b1111); check("R9 zero-fill 1", int'(q), 4'b0100);
    step(2'b01, 0, 1, 4'b1111); check("R9 zero-fill 2", int'(q), 4'b0010);
    step(2'b01, 0, 1, 4'b1111); check("R9 zero-fill 3", int'(q), 4'b0001);
    step(2'b11, 0, 0, 4'b0000);
    step(2'b01, 1, 0, 4'b0000); check("R9 one-fill 1", int'(q), 4'b1000);
    step(2'b01, 1, 0, 4'b0000); check("R9 one-fill 2", int'(q), 4'b1100);
    step(2'b01, 1, 0, 4'b0000); check("R9 one-fill 3", int'(q), 4'b1110);
    step(2'b01, 1, 0, 4'b0000); check("R9 one-fill 4", int'(q), 4'b1111);

    // Chained transfer: dut_i word 1011 into dut_b via LSB end (R7, R4)
    step(2'b11, 0, 0, 4'b1011);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      mode = 2'b01; fill_hi = 1'b0; mode_b = 2'b01; fill_hi_b = out_lo;
      @(posedge clk); #1;
    end
    @(negedge clk); mode = 2'b00; mode_b = 2'b00;
    check("R7/R4 chain target", int'(q_b), 4'b1011);
    check("R4 chain source", int'(q), 0);

    // R1: clear mid-cycle with load pending
    step(2'b11, 0, 0, 4'b0110);
    @(negedge clk); mode = 2'b11; par_in = 4'b1111;
    #2 clr_n = 1'b0; #1;
    check("R1 async clear", int'(q), 0);
    @(posedge clk); #1; check("R1 clear held", int'(q), 0);
    clr_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule